// File: doc/BRIEF.md
# Guaranteed-Latency Channel Merge Arbiter

The block merges up to eight virtual channels onto a single output link. Each channel hands in one flit at a time with a valid strobe. The flit passes through two registered levels. The first is an admission slot per channel. The second is a priority slot per channel. A binary tree then picks one flit per clock from the priority slots and places it on the link. Channel 0 has the highest rank. The link never stalls. Each source receives a one-cycle `sent` pulse when its flit leaves, and only then offers its next flit. For this reason no ready signal goes back to the sources.

Static priority alone would let a busy high-ranked channel starve the others. To prevent this, each channel keeps a wait list. When a channel's flit enters the priority level, the block records every lower-ranked channel that holds a flit anywhere in the arbiter at that moment. The channel's next flit stays in its admission slot until each recorded channel has put a flit on the link. As a result, no channel can overtake a waiting lower-ranked channel twice, which bounds the latency of every channel.

Top module: `gs_merge_arbiter`

## Requirements
- R1: While reset is low, `link_valid` and `sent` are 0. Every flit held at reset is discarded, and none appears on the link after reset is released.
- R2: A strobe on `in_valid[i]` is captured only when channel i's admission slot is empty. A strobe that arrives while the slot is occupied is ignored, and the flit already held keeps its original data.
- R3: An uncontested flit sampled at rising edge k is driven on the link after edge k+2. In that cycle `link_valid` is 1, `link_data` carries its data and `sent` has only bit i set.
- R4: Among the channels that occupy priority slots, the lowest-numbered one is sent first. Channel 0 ranks highest.
- R5: On the edge where channel i's flit enters its priority slot, its wait list is set to the channels numbered above i that hold a flit in either level on that edge. A channel whose flit leaves on the link on that same edge is excluded.
- R6: Channel i's next flit stays in its admission slot until its wait list is empty. Bit j of a wait list clears on the edge where channel j's flit is sent.
- R7: At most one flit leaves per clock. `link_valid` is 1 exactly when one bit of `sent` is set, and `link_data` is the flit of that channel.
- R8: While any priority slot is occupied, the link is valid in the next cycle, so queued flits leave back to back. A priority slot is freed on the edge where its flit is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released on a clock edge through two flops. |
| in_valid | input | NUM_CH | Per-channel flit strobe, one cycle per flit |
| in_data | input | NUM_CH*DATA_W | Per-channel flit data. Channel i uses bits [i*DATA_W +: DATA_W]. |
| link_valid | output | 1 | A flit is on the link this cycle |
| link_data | output | DATA_W | Flit on the link |
| sent | output | NUM_CH | One-hot pulse naming the channel whose flit is on the link |

## Verification
A flit sampled at an edge is seen on the link after the third rising edge, counting the sampling edge. The edges are load into admission, move into the priority level, and register onto the link. The expected timeline table is written with this three-edge offset. Each wait-list stall adds one edge after the last blocking channel is sent, because the list is cleared on that edge and is read only on the next one. Outputs are compared at the falling edge, before new inputs are driven. A channel's resend is placed in the same table row that expects its `sent` pulse, which models a source that reacts on the following edge.

// File: rtl/gsm_pkg.sv
package gsm_pkg;

  localparam int GSM_MAX_CH = 64;

  // Bits strictly above idx set (lower rank channels).
  function automatic logic [GSM_MAX_CH-1:0] mask_above(input int idx);
    logic [GSM_MAX_CH-1:0] m;
    m = '0;
    for (int k = 0; k < GSM_MAX_CH; k++) begin
      if (k > idx) m[k] = 1'b1;
    end
    return m;
  endfunction

  // Bits strictly below idx set (higher rank channels).
  function automatic logic [GSM_MAX_CH-1:0] mask_below(input int idx);
    logic [GSM_MAX_CH-1:0] m;
    m = '0;
    for (int k = 0; k < GSM_MAX_CH; k++) begin
      if (k < idx) m[k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/gsm_tree.sv
module gsm_tree #(
  parameter int NUM_CH = 8,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  output logic              any,
  output logic [IW-1:0]     win_idx
);

  localparam int NODES = 2 * NUM_CH - 1;

  // Heap order: node 0 is the root, children of k are 2k+1 and 2k+2.
  logic          nv [NODES];
  logic [IW-1:0] ni [NODES];

  genvar c, k;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_leaf
      assign nv[NUM_CH-1+c] = req[c];
      assign ni[NUM_CH-1+c] = IW'(c);
    end
    for (k = 0; k < NUM_CH - 1; k++) begin : g_node
      // Left child covers the lower-numbered channels and wins ties.
      assign nv[k] = nv[2*k+1] | nv[2*k+2];
      assign ni[k] = nv[2*k+1] ? ni[2*k+1] : ni[2*k+2];
    end
  endgenerate

  assign any     = nv[0];
  assign win_idx = ni[0];

endmodule

// File: rtl/gsm_admit.sv
module gsm_admit
  import gsm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        in_valid,
  input  logic [NUM_CH*DATA_W-1:0] in_data,
  input  logic [NUM_CH-1:0]        q_full,
  input  logic [NUM_CH-1:0]        sent_now,
  output logic [NUM_CH-1:0]        enter,
  output logic [NUM_CH*DATA_W-1:0] enter_data
);

  logic [NUM_CH-1:0] adm_full_q, adm_full_d;
  logic [NUM_CH-1:0] load;
  logic [NUM_CH-1:0] present;
  logic [DATA_W-1:0] adm_data_q [NUM_CH];
  logic [NUM_CH-1:0] wait_q     [NUM_CH];
  logic [NUM_CH-1:0] wait_d     [NUM_CH];

  assign present = adm_full_q | q_full;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      assign load[g]  = in_valid[g] & ~adm_full_q[g];
      assign enter[g] = adm_full_q[g] & ~q_full[g] & ~(|wait_q[g]);
      assign enter_data[g*DATA_W +: DATA_W] = adm_data_q[g];
    end
  endgenerate

  // Next state: admission occupancy and wait lists.
  always_comb begin
    logic [GSM_MAX_CH-1:0] am;
    adm_full_d = adm_full_q;
    for (int i = 0; i < NUM_CH; i++) begin
      am = mask_above(i);
      if (load[i])       adm_full_d[i] = 1'b1;
      else if (enter[i]) adm_full_d[i] = 1'b0;
      if (enter[i]) wait_d[i] = present & am[NUM_CH-1:0] & ~sent_now;
      else          wait_d[i] = wait_q[i] & ~sent_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adm_full_q <= '0;
      for (int i = 0; i < NUM_CH; i++) wait_q[i] <= '0;
    end else begin
      adm_full_q <= adm_full_d;
      for (int i = 0; i < NUM_CH; i++) wait_q[i] <= wait_d[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (load[i]) adm_data_q[i] <= in_data[i*DATA_W +: DATA_W];
    end
  end

  genvar ai, aj;
  generate
    for (ai = 0; ai < NUM_CH; ai++) begin : g_chk_i
      // R2: an occupied slot that does not move keeps its flit
      a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        adm_full_q[ai] && !enter[ai] |=> adm_full_q[ai] && $stable(adm_data_q[ai]));
      for (aj = 0; aj < NUM_CH; aj++) begin : g_chk_j
        // R5/R6: every channel named in a wait list still holds a flit
        a_r6_wait_pending: assert property (@(posedge clk) disable iff (!rst_n)
          wait_q[ai][aj] |-> (adm_full_q[aj] | q_full[aj]));
      end
    end
  endgenerate

endmodule

// File: rtl/gsm_queue.sv
module gsm_queue
  import gsm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        enter,
  input  logic [NUM_CH*DATA_W-1:0] enter_data,
  output logic [NUM_CH-1:0]        q_full,
  output logic [NUM_CH-1:0]        grant,
  output logic                     link_valid,
  output logic [DATA_W-1:0]        link_data,
  output logic [NUM_CH-1:0]        sent
);

  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] q_full_q, q_full_d;
  logic [DATA_W-1:0] q_data_q [NUM_CH];
  logic              any;
  logic [IW-1:0]     win_idx;
  logic              lv_q;
  logic [DATA_W-1:0] ld_q;
  logic [NUM_CH-1:0] sent_q;

  gsm_tree #(.NUM_CH(NUM_CH)) u_tree (
    .req     (q_full_q),
    .any     (any),
    .win_idx (win_idx)
  );

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) grant[i] = any & (win_idx == IW'(i));
    q_full_d = (q_full_q | enter) & ~grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_full_q <= '0;
      lv_q     <= 1'b0;
      sent_q   <= '0;
    end else begin
      q_full_q <= q_full_d;
      lv_q     <= any;
      sent_q   <= grant;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (enter[i]) q_data_q[i] <= enter_data[i*DATA_W +: DATA_W];
    end
    if (any) ld_q <= q_data_q[win_idx];
  end

  assign q_full     = q_full_q;
  assign link_valid = lv_q;
  assign link_data  = ld_q;
  assign sent       = sent_q;

  // R7: one channel per link beat
  a_r7_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    lv_q |-> $onehot(sent_q));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lv_q |-> (sent_q == '0));
  // R8: no idle link cycle while a priority slot is occupied
  a_r8_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_full_q) |=> lv_q);

  genvar pi;
  generate
    for (pi = 0; pi < NUM_CH; pi++) begin : g_prio
      localparam logic [GSM_MAX_CH-1:0] BELOW = mask_below(pi);
      // R4: the sent channel was queued and no higher-ranked one was
      a_r4_rank_order: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q[pi] |-> $past(q_full_q[pi]) &&
                       (($past(q_full_q) & BELOW[NUM_CH-1:0]) == '0));
      // R8: slot freed on the edge that sends it
      a_r8_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q[pi] |-> !q_full_q[pi]);
    end
  endgenerate

endmodule

// File: rtl/gs_merge_arbiter.sv
module gs_merge_arbiter #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        in_valid,
  input  logic [NUM_CH*DATA_W-1:0] in_data,
  output logic                     link_valid,
  output logic [DATA_W-1:0]        link_data,
  output logic [NUM_CH-1:0]        sent
);

  logic rst_meta, rst_sync;
  logic [NUM_CH-1:0]        enter, q_full, grant;
  logic [NUM_CH*DATA_W-1:0] enter_data;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  gsm_admit #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_admit (
    .clk        (clk),
    .rst_n      (rst_sync),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .q_full     (q_full),
    .sent_now   (grant),
    .enter      (enter),
    .enter_data (enter_data)
  );

  gsm_queue #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_queue (
    .clk        (clk),
    .rst_n      (rst_sync),
    .enter      (enter),
    .enter_data (enter_data),
    .q_full     (q_full),
    .grant      (grant),
    .link_valid (link_valid),
    .link_data  (link_data),
    .sent       (sent)
  );

endmodule

// File: tb/gs_merge_arbiter_test.sv
`timescale 1ns/1ps
module gs_merge_arbiter_test;

  localparam int N = 8;
  localparam int W = 16;
  localparam int STEPS = 34;

  logic           clk = 1'b0;
  logic           rst_n = 1'b1;
  logic [N-1:0]   in_valid = '0;
  logic [N*W-1:0] in_data = '0;
  logic           link_valid;
  logic [W-1:0]   link_data;
  logic [N-1:0]   sent;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0]   seq = 8'h00;
  logic [W-1:0] drv_data [N];

  always #2 clk = ~clk;

  gs_merge_arbiter #(.NUM_CH(N), .DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .link_valid(link_valid), .link_data(link_data), .sent(sent)
  );

  // {strobe mask, expected link_valid, expected sent}; checked before the drive
  localparam logic [16:0] VEC [STEPS] = '{
    {8'h04,1'b0,8'h00}, {8'h00,1'b0,8'h00}, {8'h00,1'b0,8'h00}, {8'h00,1'b1,8'h04},
    {8'hE1,1'b0,8'h00}, {8'h00,1'b0,8'h00}, {8'h00,1'b0,8'h00}, {8'h01,1'b1,8'h01},
    {8'h00,1'b1,8'h20}, {8'h00,1'b1,8'h40}, {8'h00,1'b1,8'h80}, {8'h00,1'b0,8'h00},
    {8'h00,1'b1,8'h01},
    {8'hFF,1'b0,8'h00}, {8'h00,1'b0,8'h00}, {8'h00,1'b0,8'h00}, {8'h00,1'b1,8'h01},
    {8'h00,1'b1,8'h02}, {8'h00,1'b1,8'h04}, {8'h00,1'b1,8'h08}, {8'h00,1'b1,8'h10},
    {8'h00,1'b1,8'h20}, {8'h00,1'b1,8'h40}, {8'h00,1'b1,8'h80}, {8'h00,1'b0,8'h00},
    {8'h03,1'b0,8'h00}, {8'h00,1'b0,8'h00}, {8'h00,1'b0,8'h00}, {8'h09,1'b1,8'h01},
    {8'h00,1'b1,8'h02}, {8'h00,1'b0,8'h00}, {8'h00,1'b1,8'h01}, {8'h00,1'b1,8'h08},
    {8'h00,1'b0,8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] mask);
    in_valid = mask;
    for (int c = 0; c < N; c++) begin
      if (mask[c]) begin
        drv_data[c] = {c[3:0], 4'hA, seq};
        in_data[c*W +: W] = drv_data[c];
        seq++;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    logic [W-1:0] exp_d;
    for (int c = 0; c < N; c++) drv_data[c] = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(link_valid == 1'b0, "R1 valid in reset", 32'(link_valid), 0);
    chk(sent == '0, "R1 sent in reset", 32'(sent), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(link_valid == 1'b0 && sent == '0, "R1 after release", 32'(sent), 0);

    for (int s = 0; s < STEPS; s++) begin
      @(negedge clk);
      if (s < 4)       tag = "R3";
      else if (s < 13) tag = "R5 R6";
      else if (s < 25) tag = "R4 R8";
      else             tag = "R4 R5";
      chk(link_valid == VEC[s][8], {tag, " R7 valid"}, 32'(link_valid), 32'(VEC[s][8]));
      chk(sent == VEC[s][7:0], {tag, " sent"}, 32'(sent), 32'(VEC[s][7:0]));
      if (VEC[s][8]) begin
        exp_d = '0;
        for (int c = 0; c < N; c++) if (VEC[s][c]) exp_d = drv_data[c];
        chk(link_data == exp_d, {tag, " R7 data"}, 32'(link_data), 32'(exp_d));
      end
      drive(VEC[s][16:9]);
    end

    // R2: strobe while the admission slot is full is ignored
    @(negedge clk);
    in_valid = 8'h10; in_data[4*W +: W] = 16'h4111;
    @(negedge clk);
    in_data[4*W +: W] = 16'h4222;
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    chk(link_valid && sent == 8'h10, "R2 first flit sent", 32'(sent), 32'h10);
    chk(link_data == 16'h4111, "R2 original data kept", 32'(link_data), 32'h4111);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(link_valid == 1'b0, "R2 second strobe dropped", 32'(link_valid), 0);
    end

    // R1: reset in the middle of traffic discards held flits
    drive(8'hFF);
    @(negedge clk);
    drive(8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(link_valid == 1'b0 && sent == '0, "R1 async clear", 32'(sent), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(link_valid == 1'b0, "R1 no stale flit", 32'(link_valid), 0);
    end

    // R3: normal service resumes after reset
    drive(8'h80);
    @(negedge clk);
    drive(8'h00);
    repeat (2) @(negedge clk);
    chk(link_valid && sent == 8'h80, "R3 after reset", 32'(sent), 32'h80);
    chk(link_data == drv_data[7], "R3 data after reset", 32'(link_data), 32'(drv_data[7]));

    finish_run();
  end

endmodule